// File: doc/BRIEF.md
# Compare/Capture Timer Channel

A single 16-bit up-counting timer channel with two general registers, A and B. Each general register works either as an output compare or as an input capture. In compare mode a match drives its output pin low, drives it high or toggles it. In capture mode an edge on its capture pin copies the running count into the register.

The counter advances on one of four prescaled taps of the system clock, or on chosen edges of one of four external clock pins. It can be cleared by a match on either register, which turns the channel into a periodic tick source. Three sticky flags are cleared by software: match/capture A, match/capture B and overflow. Each flag has its own enable onto one interrupt line. Software reaches every register through a plain address, write-data, write-strobe and read-strobe bus. Reads return data combinationally.

Top module: `cc_timer_chan`

## Requirements
- R1: After reset the counter, both general registers, all flags, both compare outputs and the interrupt output are 0.
- R2: The counter advances only while the start bit (address 4, bit 0) is 1. A bus write to the counter (address 5) loads it directly and overrides counting.
- R3: Control bits 2:0 with values 0, 1, 2 and 3 advance the counter on every system clock, every 2nd, every 4th and every 8th clock respectively.
- R4: Control bits 2:0 with values 4 to 7 count edges of external clock pin 0 to 3. Control bits 4:3 pick the edges: 00 rising, 01 falling, 1x both. The pins that are not selected have no effect.
- R5: Control bits 6:5 pick the clear source: 00 none, 01 match on A, 10 match on B. With a match clear the counter goes to 0 on the tick after the tick where it equals the compare value, so one period is compare value + 1 ticks.
- R6: With control bits 6:5 = 11, writing the start bit from 0 to 1 zeroes the counter.
- R7: The I/O field of A is in I/O control (address 1) bits 2:0, and the field of B is in bits 6:4. Code 0 compares with no pin change, 1 drives 0 on a match, 2 drives 1 on a match and 3 toggles on a match. The compare outputs reset to 0.
- R8: Codes 4, 5 and 6/7 capture on a rising, falling or any edge of the register's capture pin. A capture loads the current count and sets the register's flag. In capture mode the compare output holds its value.
- R9: The overflow flag (status bit 2) sets when the counter wraps from 0xFFFF to 0x0000.
- R10: Status (address 2) bits 0, 1 and 2 are the A, B and overflow flags. A flag clears only when written 0 after a read that saw it set. A hardware set in the same cycle wins.
- R11: Interrupt enable (address 3) bits 0, 1 and 2 gate the A, B and overflow flags onto the interrupt output.
- R12: Address map: 0 control, 1 I/O control, 2 status, 3 interrupt enable, 4 start, 5 counter, 6 register A, 7 register B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 3 | Register address |
| busWdata | input | 16 | Write data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busRdata | output | 16 | Read data, combinational |
| extClk | input | 4 | External clock pins |
| capA | input | 1 | Capture pin for register A |
| capB | input | 1 | Capture pin for register B |
| cmpOutA | output | 1 | Compare output A |
| cmpOutB | output | 1 | Compare output B |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler phase or a wrong clear condition shows up as a wrong spacing between toggles of a compare pin, within one period of the timer. A broken count hold or sync clear shows up in the counter readback two edges after the start write. A flag that clears without the read-then-write sequence, or an enable that leaks, shows up on the interrupt pin in the very next cycle. The capture path and the external clock path are checked through the general register and counter readbacks, a few cycles after the synchronizer delay.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int CNT_W   = 16;
  localparam int N_EXT   = 4;
  localparam int PRE_W   = 3;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_IO    = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_IEN   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_START = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_CNT   = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_REGA  = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_REGB  = 3'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic             run;
    logic             startClr;
    logic             wrCnt;
    logic             wrRegA;
    logic             wrRegB;
    logic [CNT_W-1:0] wdata;
  } strobes_t;

  // static configuration fields
  typedef struct packed {
    logic [2:0] clkSel;
    logic [1:0] edgeSel;
    logic [1:0] clrSel;
    logic [2:0] ioA;
    logic [2:0] ioB;
  } cfg_t;

  // events from datapath to control
  typedef struct packed {
    logic ovf;
    logic hitB;
    logic hitA;
  } events_t;
endpackage

// File: rtl/cct_datapath.sv
module cct_datapath
  import cct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         stb,
  input  cfg_t             cfg,
  input  logic [N_EXT-1:0] extClk,
  input  logic             capA,
  input  logic             capB,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] regA,
  output logic [CNT_W-1:0] regB,
  output events_t          ev,
  output logic             outA,
  output logic             outB
);
  localparam int N_IN = N_EXT + 2;

  logic [PRE_W-1:0] preDiv;
  logic             intTick;
  logic [N_IN-1:0]  rawIn;
  logic [N_IN-1:0]  rise;
  logic [N_IN-1:0]  fall;
  logic             extTick;
  logic             tick;
  logic             adv;
  logic             capModeA;
  logic             capModeB;
  logic             cmpA;
  logic             cmpB;
  logic             capEvA;
  logic             capEvB;
  logic             clrNow;

  // free-running prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preDiv <= '0;
    else       preDiv <= preDiv + 1'b1;
  end

  always_comb begin
    case (cfg.clkSel[1:0])
      2'd0:    intTick = 1'b1;
      2'd1:    intTick = preDiv[0];
      2'd2:    intTick = &preDiv[1:0];
      default: intTick = &preDiv;
    endcase
  end

  assign rawIn = {capB, capA, extClk};

  // synchronizers and edge detectors for every pin
  for (genvar i = 0; i < N_IN; i++) begin : g_sync
    logic [SYNC_STAGES:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-1:0], rawIn[i]};
    end
    assign rise[i] = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
    assign fall[i] = ~chain[SYNC_STAGES-1] & chain[SYNC_STAGES];
  end

  always_comb begin
    case (cfg.edgeSel)
      2'b00:   extTick = rise[cfg.clkSel[1:0]];
      2'b01:   extTick = fall[cfg.clkSel[1:0]];
      default: extTick = rise[cfg.clkSel[1:0]] | fall[cfg.clkSel[1:0]];
    endcase
  end

  assign tick = cfg.clkSel[2] ? extTick : intTick;
  assign adv  = stb.run & tick;

  function automatic logic capEdge(input logic [2:0] code, input logic r, input logic f);
    case (code)
      3'd4:    capEdge = r;
      3'd5:    capEdge = f;
      default: capEdge = r | f;
    endcase
  endfunction

  assign capModeA = cfg.ioA[2];
  assign capModeB = cfg.ioB[2];
  assign cmpA     = ~capModeA & adv & (cnt == regA);
  assign cmpB     = ~capModeB & adv & (cnt == regB);
  assign capEvA   = capModeA & capEdge(cfg.ioA, rise[N_EXT], fall[N_EXT]);
  assign capEvB   = capModeB & capEdge(cfg.ioB, rise[N_EXT+1], fall[N_EXT+1]);
  assign clrNow   = ((cfg.clrSel == 2'b01) & cmpA) | ((cfg.clrSel == 2'b10) & cmpB);

  assign ev.hitA = cmpA | capEvA;
  assign ev.hitB = cmpB | capEvB;
  assign ev.ovf  = adv & ~clrNow & (cnt == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (stb.wrCnt)    cnt <= stb.wdata;
    else if (stb.startClr) cnt <= '0;
    else if (adv)          cnt <= clrNow ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           regA <= '0;
    else if (capEvA)     regA <= cnt;
    else if (stb.wrRegA) regA <= stb.wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           regB <= '0;
    else if (capEvB)     regB <= cnt;
    else if (stb.wrRegB) regB <= stb.wdata;
  end

  function automatic logic pinNext(input logic [2:0] code, input logic cur, input logic hit);
    if (!hit) return cur;
    case (code)
      3'd1:    return 1'b0;
      3'd2:    return 1'b1;
      3'd3:    return ~cur;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outA <= 1'b0;
      outB <= 1'b0;
    end else begin
      outA <= pinNext(cfg.ioA, outA, cmpA);
      outB <= pinNext(cfg.ioB, outB, cmpB);
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.run && !stb.wrCnt && !stb.startClr) |=> $stable(cnt)); // R2
  AST_MATCH_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ((cfg.clrSel == 2'b01) && cmpA && !stb.wrCnt && !stb.startClr) |=> (cnt == '0)); // R5
  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.startClr && !stb.wrCnt) |=> (cnt == '0)); // R6
  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    capEvA |=> (regA == $past(cnt))); // R8
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    capModeA |=> $stable(outA)); // R8
endmodule

// File: rtl/cct_ctrl.sv
module cct_ctrl
  import cct_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  input  logic              busWr,
  input  logic              busRd,
  output logic [CNT_W-1:0]  busRdata,
  input  events_t           ev,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  regA,
  input  logic [CNT_W-1:0]  regB,
  output strobes_t          stb,
  output cfg_t              cfg,
  output logic              irq
);
  logic [7:0] ctrlReg;
  logic [7:0] ioReg;
  logic [2:0] ienReg;
  logic       startBit;
  logic [2:0] flags;
  logic [2:0] armed;
  logic [2:0] swClr;
  logic       rdStat;
  logic       wrStat;

  assign rdStat = busRd & (busAddr == ADR_STAT);
  assign wrStat = busWr & (busAddr == ADR_STAT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      ioReg    <= '0;
      ienReg   <= '0;
      startBit <= 1'b0;
    end else if (busWr) begin
      case (busAddr)
        ADR_CTRL:  ctrlReg  <= busWdata[7:0];
        ADR_IO:    ioReg    <= busWdata[7:0];
        ADR_IEN:   ienReg   <= busWdata[2:0];
        ADR_START: startBit <= busWdata[0];
        default:   ;
      endcase
    end
  end

  assign cfg.clkSel  = ctrlReg[2:0];
  assign cfg.edgeSel = ctrlReg[4:3];
  assign cfg.clrSel  = ctrlReg[6:5];
  assign cfg.ioA     = ioReg[2:0];
  assign cfg.ioB     = ioReg[6:4];

  assign stb.run      = startBit;
  assign stb.startClr = busWr & (busAddr == ADR_START) & busWdata[0] & ~startBit
                        & (ctrlReg[6:5] == 2'b11);
  assign stb.wrCnt    = busWr & (busAddr == ADR_CNT);
  assign stb.wrRegA   = busWr & (busAddr == ADR_REGA);
  assign stb.wrRegB   = busWr & (busAddr == ADR_REGB);
  assign stb.wdata    = busWdata;

  // a zero write clears only flags seen set by an earlier read
  assign swClr = {3{wrStat}} & ~busWdata[2:0] & armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
      armed <= '0;
    end else begin
      flags <= {ev.ovf, ev.hitB, ev.hitA} | (flags & ~swClr);
      armed <= (armed & ~swClr) | (rdStat ? flags : 3'b000);
    end
  end

  assign irq = |(flags & ienReg);

  always_comb begin
    case (busAddr)
      ADR_CTRL:  busRdata = {8'h00, ctrlReg};
      ADR_IO:    busRdata = {8'h00, ioReg};
      ADR_STAT:  busRdata = {13'h0, flags};
      ADR_IEN:   busRdata = {13'h0, ienReg};
      ADR_START: busRdata = {15'h0, startBit};
      ADR_CNT:   busRdata = cnt;
      ADR_REGA:  busRdata = regA;
      default:   busRdata = regB;
    endcase
  end

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ev.ovf |=> flags[2]); // R9
  AST_HW_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ev.hitA |=> flags[0]); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flags[0] && !wrStat) |=> flags[0]); // R10
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (ienReg == 3'b000) |-> !irq); // R11
endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan
  import cct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  input  logic              busWr,
  input  logic              busRd,
  output logic [CNT_W-1:0]  busRdata,
  input  logic [N_EXT-1:0]  extClk,
  input  logic              capA,
  input  logic              capB,
  output logic              cmpOutA,
  output logic              cmpOutB,
  output logic              irq
);
  strobes_t         stb;
  cfg_t             cfg;
  events_t          ev;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] regA;
  logic [CNT_W-1:0] regB;

  cct_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWr(busWr), .busRd(busRd), .busRdata(busRdata), .ev(ev),
    .cnt(cnt), .regA(regA), .regB(regB), .stb(stb), .cfg(cfg), .irq(irq)
  );

  cct_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfg(cfg), .extClk(extClk),
    .capA(capA), .capB(capB), .cnt(cnt), .regA(regA), .regB(regB),
    .ev(ev), .outA(cmpOutA), .outB(cmpOutB)
  );
endmodule

// File: tb/tb_cc_timer_chan.sv
module tb_cc_timer_chan;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [15:0] busRdata;
  logic [3:0]  extClk = '0;
  logic        capA = 1'b0;
  logic        capB = 1'b0;
  logic        cmpOutA;
  logic        cmpOutB;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  typedef struct {
    string       req;
    logic [15:0] exp;
    logic [15:0] act;
  } item_t;
  item_t sbq[$];

  always #10 clk = ~clk;

  cc_timer_chan dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWr(busWr), .busRd(busRd), .busRdata(busRdata), .extClk(extClk),
    .capA(capA), .capB(capB), .cmpOutA(cmpOutA), .cmpOutB(cmpOutB), .irq(irq)
  );

  // driver side: push expected item with observed value
  task automatic push(input string req, input logic [15:0] exp, input logic [15:0] act);
    item_t it;
    it.req = req; it.exp = exp; it.act = act;
    sbq.push_back(it);
  endtask

  // monitor side: pop and compare
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      compared++;
      if (it.act !== it.exp) begin
        mismatched++;
        $display("FAIL %s: actual %h expected %h", it.req, it.act, it.exp);
      end
    end
  end

  task automatic wrReg(input logic [2:0] a, input logic [15:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [15:0] d);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic gapA(output int gap);
    logic last;
    last = cmpOutA;
    while (cmpOutA == last) @(negedge clk);
    last = cmpOutA;
    gap = 0;
    while (cmpOutA == last) begin
      @(negedge clk);
      gap++;
    end
  endtask

  task automatic pulseExt(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      extClk[idx] = 1'b1; idle(4);
      extClk[idx] = 1'b0; idle(4);
    end
  endtask

  task automatic clearFlags();
    logic [15:0] d;
    rdReg(3'd2, d);
    wrReg(3'd2, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int g;
    logic holdA;
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    rdReg(3'd2, d); push("R1 status", 16'h0, d);
    rdReg(3'd5, d); push("R1 counter", 16'h0, d);
    rdReg(3'd6, d); push("R1 regA", 16'h0, d);
    push("R1 outputs/irq", 16'h0, {13'h0, cmpOutA, cmpOutB, irq});

    // R2 hold while stopped, load, and counting while started (R12 map)
    wrReg(3'd5, 16'd5);
    idle(10);
    rdReg(3'd5, d); push("R2 hold", 16'd5, d);
    wrReg(3'd4, 16'd1);
    idle(3);
    wrReg(3'd4, 16'd0);
    rdReg(3'd5, d); push("R2 advance", 16'd9, d);

    // R5/R3 periodic clear on A with toggle output (R7)
    wrReg(3'd0, 16'h0020);
    wrReg(3'd6, 16'd4);
    wrReg(3'd1, 16'h0003);
    wrReg(3'd3, 16'h0001);
    wrReg(3'd5, 16'd0);
    wrReg(3'd4, 16'd1);
    gapA(g); push("R5 period phi", 16'd5, 16'(g));
    push("R11 irq on A", 16'h1, {15'h0, irq});
    wrReg(3'd0, 16'h0021); gapA(g); gapA(g); push("R3 phi/2", 16'd10, 16'(g));
    wrReg(3'd0, 16'h0022); gapA(g); gapA(g); push("R3 phi/4", 16'd20, 16'(g));
    wrReg(3'd0, 16'h0023); gapA(g); gapA(g); push("R3 phi/8", 16'd40, 16'(g));
    wrReg(3'd0, 16'h0020);
    begin
      logic over;
      over = 1'b0;
      for (int k = 0; k < 20; k++) begin
        rdReg(3'd5, d);
        if (d > 16'd4) over = 1'b1;
      end
      push("R5 bound", 16'h0, {15'h0, over});
    end

    // R7 drive 1 / drive 0 on B
    wrReg(3'd7, 16'd2);
    wrReg(3'd1, 16'h0023);
    idle(10);
    push("R7 drive1", 16'h1, {15'h0, cmpOutB});
    wrReg(3'd1, 16'h0013);
    idle(10);
    push("R7 drive0", 16'h0, {15'h0, cmpOutB});

    // R10 / R11 flag clearing and gating
    wrReg(3'd4, 16'd0);
    wrReg(3'd3, 16'h0000);
    push("R11 masked", 16'h0, {15'h0, irq});
    wrReg(3'd3, 16'h0001);
    wrReg(3'd2, 16'h0000);
    rdReg(3'd2, d); push("R10 unarmed write", 16'h1, {15'h0, d[0]});
    wrReg(3'd2, 16'h0000);
    rdReg(3'd2, d); push("R10 armed clear", 16'h0, d);
    push("R11 irq dropped", 16'h0, {15'h0, irq});

    // R9 overflow
    wrReg(3'd0, 16'h0000);
    wrReg(3'd1, 16'h0000);
    wrReg(3'd3, 16'h0004);
    wrReg(3'd5, 16'hFFFD);
    wrReg(3'd4, 16'd1);
    idle(8);
    wrReg(3'd4, 16'd0);
    rdReg(3'd2, d); push("R9 ovf flag", 16'h1, {15'h0, d[2]});
    push("R11 irq ovf", 16'h1, {15'h0, irq});
    clearFlags();
    wrReg(3'd3, 16'h0000);

    // R6 synchronized clear at start
    wrReg(3'd0, 16'h0060);
    wrReg(3'd5, 16'd77);
    wrReg(3'd4, 16'd1);
    wrReg(3'd4, 16'd0);
    rdReg(3'd5, d); push("R6 start clear", 16'd1, d);
    wrReg(3'd0, 16'h0000);
    wrReg(3'd5, 16'd77);
    wrReg(3'd4, 16'd1);
    wrReg(3'd4, 16'd0);
    rdReg(3'd5, d); push("R6 no clear", 16'd78, d);

    // R4 external clock pin 0
    wrReg(3'd0, 16'h0004);
    wrReg(3'd5, 16'd0);
    wrReg(3'd4, 16'd1);
    pulseExt(0, 6);
    rdReg(3'd5, d); push("R4 rising", 16'd6, d);
    wrReg(3'd0, 16'h0014);
    wrReg(3'd5, 16'd0);
    pulseExt(0, 6);
    rdReg(3'd5, d); push("R4 both", 16'd12, d);
    wrReg(3'd0, 16'h000C);
    wrReg(3'd5, 16'd0);
    pulseExt(0, 6);
    rdReg(3'd5, d); push("R4 falling", 16'd6, d);
    pulseExt(1, 4);
    rdReg(3'd5, d); push("R4 other pin", 16'd6, d);
    wrReg(3'd4, 16'd0);

    // R8 capture on A
    wrReg(3'd0, 16'h0000);
    clearFlags();
    holdA = cmpOutA;
    wrReg(3'd1, 16'h0004);
    wrReg(3'd5, 16'h1234);
    capA = 1'b1; idle(5);
    rdReg(3'd6, d); push("R8 capture rise", 16'h1234, d);
    rdReg(3'd2, d); push("R8 capture flag", 16'h1, {15'h0, d[0]});
    capA = 1'b0; idle(5);
    wrReg(3'd1, 16'h0005);
    wrReg(3'd5, 16'h2222);
    capA = 1'b1; idle(5);
    rdReg(3'd6, d); push("R8 rise ignored", 16'h1234, d);
    capA = 1'b0; idle(5);
    rdReg(3'd6, d); push("R8 capture fall", 16'h2222, d);
    push("R8 output held", {15'h0, holdA}, {15'h0, cmpOutA});

    wait (sbq.size() == 0);
    idle(2);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule